// File: doc/BRIEF.md
# Direct Torque Control Decision Stage

This block turns estimated and commanded drive quantities into one inverter switch pattern per control period. It compares the estimated stator-flux magnitude with its command through a two-level hysteresis element. It compares the estimated torque with its command through a three-level hysteresis element. It also places the flux angle into one of six 60-degree sectors. From those three results it chooses the on/off state of the three inverter legs.

Each decision is taken on a one-cycle sample strobe. The comparator states, the sector and the leg pattern are registered together on that edge, so all outputs change in the same cycle. Both hysteresis band widths are ordinary inputs and can be changed while the drive runs. The angle is a binary fraction of a full turn: 0 is 0 degrees and 2^AW is 360 degrees.

Top module: `dtc_vector_select`

## Requirements
- R1: A synchronous active-high reset forces `sw_vec` to 000, `flux_state` to 0, `torq_state` to 00 and `sector` to 1, whatever the other inputs are.
- R2: Outputs change only at a rising edge where `sample` is high, and they reflect that edge's inputs from the next cycle on. With `sample` low, every output holds its value for any input change.
- R3: The flux error is `flux_ref - flux_est` and half the band is `flux_band >> 1`. The flux state becomes 1 when the error is strictly above half the band. It becomes 0 when the error is strictly below minus half the band. Otherwise it keeps its previous value. A new band takes effect at the next strobe.
- R4: The torque error is `torq_ref - torq_est` and half the band is `torq_band >> 1`. `torq_state` is encoded as 01 for increase, 11 for decrease and 00 for hold. The state goes to 01 when the error is above half the band and to 11 when it is below minus half the band. From 01 it returns to 00 when the error is zero or negative. From 11 it returns to 00 when the error is zero or positive. Otherwise it holds.
- R5: The sector is 1 + ((6*angle + 2^(AW-1)) >> AW) mod 6. Sector 1 therefore covers -30 to +30 degrees, and each following sector lies 60 degrees further counter-clockwise. An angle exactly on a boundary belongs to the higher-numbered sector. The sector is encoded as the binary number 1 to 6.
- R6: With a nonzero torque state, `sw_vec` = {Sa,Sb,Sc} is the active pattern P(k), where P(0..5) = 100, 110, 010, 011, 001, 101. The index is k = (sector - 1 + d) mod 6, with d = 1 for flux 1 and increase, 5 for flux 1 and decrease, 2 for flux 0 and increase, and 4 for flux 0 and decrease.
- R7: With torque state 00, `sw_vec` is a zero pattern. It is 111 when the flux state equals the low bit of the sector number and 000 otherwise. So with flux 1 it is 111 in odd sectors and 000 in even ones, and with flux 0 this is reversed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample | input | 1 | Decision strobe, one cycle wide |
| flux_est | input | DW | Estimated flux magnitude, unsigned |
| flux_ref | input | DW | Commanded flux magnitude, unsigned |
| flux_band | input | DW | Full flux hysteresis width, unsigned |
| torq_est | input | DW | Estimated torque, signed |
| torq_ref | input | DW | Commanded torque, signed |
| torq_band | input | DW | Full torque hysteresis width, unsigned |
| angle | input | AW | Flux angle as a binary fraction of a turn |
| flux_state | output | 1 | Registered flux comparator state |
| torq_state | output | 2 | Registered torque comparator state (01 inc, 11 dec, 00 hold) |
| sector | output | 3 | Registered sector number 1..6 |
| sw_vec | output | 3 | Registered leg pattern {Sa,Sb,Sc} |

## Verification
Comparator updates and the table lookup fall in the same strobe edge. The leg pattern must therefore be chosen from the states that are being written in that edge, not from the ones already held. The bench provokes this by moving the torque error across zero, or across a band edge, at a fixed angle. At that strobe the comparator state and the zero-or-active choice flip together, and the bench judges the pattern and the state together in the cycle after the strobe. A full sweep of every angle code under every flux/torque combination covers the sector boundaries and the zero-pattern parity.

// File: rtl/dtc_pkg.sv
package dtc_pkg;

  typedef enum logic [1:0] {
    TQ_HOLD = 2'b00,
    TQ_INC  = 2'b01,
    TQ_DEC  = 2'b11
  } torq_cmd_t;

  localparam int NUM_SECTORS = 6;

  // active leg patterns {Sa,Sb,Sc}, 60 degrees apart, counter-clockwise
  function automatic logic [2:0] active_pattern(input logic [2:0] idx);
    case (idx)
      3'd0:    active_pattern = 3'b100;
      3'd1:    active_pattern = 3'b110;
      3'd2:    active_pattern = 3'b010;
      3'd3:    active_pattern = 3'b011;
      3'd4:    active_pattern = 3'b001;
      3'd5:    active_pattern = 3'b101;
      default: active_pattern = 3'b000;
    endcase
  endfunction

endpackage

// File: rtl/dtc_flux_hyst.sv
module dtc_flux_hyst #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          upd,
  input  logic [DW-1:0] ref_mag,
  input  logic [DW-1:0] est_mag,
  input  logic [DW-1:0] band,
  output logic          state_q,
  output logic          state_nx
);
  localparam int EW = DW + 1;

  logic signed [EW-1:0] err;
  logic signed [EW-1:0] half;

  always_comb begin
    err  = $signed({1'b0, ref_mag}) - $signed({1'b0, est_mag});
    half = $signed({1'b0, band} >> 1);
    state_nx = state_q;
    if (err > half)       state_nx = 1'b1;
    else if (err < -half) state_nx = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)      state_q <= 1'b0;
    else if (upd) state_q <= state_nx;
  end
endmodule

// File: rtl/dtc_torq_hyst.sv
module dtc_torq_hyst
  import dtc_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 upd,
  input  logic signed [DW-1:0] ref_trq,
  input  logic signed [DW-1:0] est_trq,
  input  logic        [DW-1:0] band,
  output torq_cmd_t            state_q,
  output torq_cmd_t            state_nx
);
  localparam int EW = DW + 1;

  logic signed [EW-1:0] err;
  logic signed [EW-1:0] half;

  always_comb begin
    err  = $signed({ref_trq[DW-1], ref_trq}) - $signed({est_trq[DW-1], est_trq});
    half = $signed({1'b0, band} >> 1);
    state_nx = state_q;
    if (err > half)                            state_nx = TQ_INC;
    else if (err < -half)                      state_nx = TQ_DEC;
    else if (state_q == TQ_INC && err <= 0)    state_nx = TQ_HOLD;
    else if (state_q == TQ_DEC && err >= 0)    state_nx = TQ_HOLD;
  end

  always_ff @(posedge clk) begin
    if (rst)      state_q <= TQ_HOLD;
    else if (upd) state_q <= state_nx;
  end
endmodule

// File: rtl/dtc_sector_calc.sv
module dtc_sector_calc
  import dtc_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [AW-1:0] angle,
  output logic [2:0]    sector_nx
);
  localparam int PW = AW + 3;
  localparam logic [PW-1:0] HALF_STEP = PW'(1) << (AW - 1);

  logic [PW-1:0]          scaled;
  logic [NUM_SECTORS-1:0] past_edge;

  assign scaled = PW'(angle) * PW'(6) + HALF_STEP;

  // one comparator per sector edge; the count of edges passed is the index
  for (genvar k = 1; k <= NUM_SECTORS; k++) begin : g_edge
    localparam logic [PW-1:0] EDGE = PW'(k) << AW;
    assign past_edge[k-1] = (scaled >= EDGE);
  end

  always_comb begin
    logic [2:0] idx;
    idx = 3'($countones(past_edge));
    sector_nx = (idx == 3'(NUM_SECTORS)) ? 3'd1 : idx + 3'd1;
  end
endmodule

// File: rtl/dtc_switch_table.sv
module dtc_switch_table
  import dtc_pkg::*;
(
  input  logic       flux_cmd,
  input  torq_cmd_t  torq_cmd,
  input  logic [2:0] sector,
  output logic [2:0] pattern
);
  always_comb begin
    logic [3:0] step;
    logic [3:0] sum;
    case ({flux_cmd, torq_cmd == TQ_INC})
      2'b11:   step = 4'd1;
      2'b10:   step = 4'd5;
      2'b01:   step = 4'd2;
      default: step = 4'd4;
    endcase
    sum = {1'b0, sector} - 4'd1 + step;
    if (sum >= 4'(NUM_SECTORS)) sum = sum - 4'(NUM_SECTORS);
    if (torq_cmd == TQ_HOLD)
      pattern = (flux_cmd == sector[0]) ? 3'b111 : 3'b000;
    else
      pattern = active_pattern(sum[2:0]);
  end
endmodule

// File: rtl/dtc_vector_select.sv
module dtc_vector_select
  import dtc_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sample,
  input  logic        [DW-1:0] flux_est,
  input  logic        [DW-1:0] flux_ref,
  input  logic        [DW-1:0] flux_band,
  input  logic signed [DW-1:0] torq_est,
  input  logic signed [DW-1:0] torq_ref,
  input  logic        [DW-1:0] torq_band,
  input  logic        [AW-1:0] angle,
  output logic                 flux_state,
  output logic        [1:0]    torq_state,
  output logic        [2:0]    sector,
  output logic        [2:0]    sw_vec
);
  logic      flux_nx;
  torq_cmd_t torq_q;
  torq_cmd_t torq_nx;
  logic [2:0] sector_nx;
  logic [2:0] pattern_nx;

  dtc_flux_hyst #(.DW(DW)) u_flux (
    .clk(clk), .rst(rst), .upd(sample),
    .ref_mag(flux_ref), .est_mag(flux_est), .band(flux_band),
    .state_q(flux_state), .state_nx(flux_nx)
  );

  dtc_torq_hyst #(.DW(DW)) u_torq (
    .clk(clk), .rst(rst), .upd(sample),
    .ref_trq(torq_ref), .est_trq(torq_est), .band(torq_band),
    .state_q(torq_q), .state_nx(torq_nx)
  );

  dtc_sector_calc #(.AW(AW)) u_sector (
    .angle(angle), .sector_nx(sector_nx)
  );

  // lookup uses the states being written this edge
  dtc_switch_table u_table (
    .flux_cmd(flux_nx), .torq_cmd(torq_nx), .sector(sector_nx),
    .pattern(pattern_nx)
  );

  assign torq_state = torq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sector <= 3'd1;
      sw_vec <= 3'b000;
    end else if (sample) begin
      sector <= sector_nx;
      sw_vec <= pattern_nx;
    end
  end
endmodule

// File: rtl/dtc_vector_select_chk.sv
module dtc_vector_select_chk #(
  parameter int DW = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 sample,
  input logic        [DW-1:0] flux_est,
  input logic        [DW-1:0] flux_ref,
  input logic        [DW-1:0] flux_band,
  input logic signed [DW-1:0] torq_est,
  input logic signed [DW-1:0] torq_ref,
  input logic        [DW-1:0] torq_band,
  input logic                 flux_state,
  input logic        [1:0]    torq_state,
  input logic        [2:0]    sector,
  input logic        [2:0]    sw_vec
);
  logic signed [DW:0] ferr, fhalf, terr, thalf;
  assign ferr  = $signed({1'b0, flux_ref}) - $signed({1'b0, flux_est});
  assign fhalf = $signed({1'b0, flux_band} >> 1);
  assign terr  = $signed({torq_ref[DW-1], torq_ref}) - $signed({torq_est[DW-1], torq_est});
  assign thalf = $signed({1'b0, torq_band} >> 1);

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (sw_vec == 3'b000 && !flux_state && torq_state == 2'b00 && sector == 3'd1));

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !sample |=> ($stable(sw_vec) && $stable(sector) && $stable(flux_state) && $stable(torq_state)));

  assert_flux_band_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (sample && ferr <= fhalf && ferr >= -fhalf) |=> (flux_state == $past(flux_state)));

  assert_torq_rise_R4: assert property (@(posedge clk) disable iff (rst)
    (sample && terr > thalf) |=> (torq_state == 2'b01));

  assert_sector_range_R5: assert property (@(posedge clk) disable iff (rst)
    (sector >= 3'd1 && sector <= 3'd6));

  assert_active_nonzero_R6: assert property (@(posedge clk) disable iff (rst)
    (torq_state != 2'b00) |-> (sw_vec != 3'b000 && sw_vec != 3'b111));

  assert_zero_parity_R7: assert property (@(posedge clk) disable iff (rst)
    (torq_state == 2'b00) |-> (sw_vec == ((flux_state == sector[0]) ? 3'b111 : 3'b000)));
endmodule

bind dtc_vector_select dtc_vector_select_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .sample(sample),
  .flux_est(flux_est), .flux_ref(flux_ref), .flux_band(flux_band),
  .torq_est(torq_est), .torq_ref(torq_ref), .torq_band(torq_band),
  .flux_state(flux_state), .torq_state(torq_state),
  .sector(sector), .sw_vec(sw_vec)
);

// File: tb/dtc_vector_select_bench.sv
`timescale 1ns/1ps
module dtc_vector_select_bench;
  localparam int DW = 8;
  localparam int AW = 8;

  logic clk = 1'b0, rst = 1'b1, sample = 1'b0;
  logic        [DW-1:0] flux_est = '0, flux_ref = '0, flux_band = 8'd20, torq_band = 8'd20;
  logic signed [DW-1:0] torq_est = '0, torq_ref = '0;
  logic        [AW-1:0] angle = '0;
  logic       flux_state;
  logic [1:0] torq_state;
  logic [2:0] sector, sw_vec;

  dtc_vector_select #(.DW(DW), .AW(AW)) u_dtc_vector_select (
    .clk(clk), .rst(rst), .sample(sample),
    .flux_est(flux_est), .flux_ref(flux_ref), .flux_band(flux_band),
    .torq_est(torq_est), .torq_ref(torq_ref), .torq_band(torq_band),
    .angle(angle), .flux_state(flux_state), .torq_state(torq_state),
    .sector(sector), .sw_vec(sw_vec)
  );

  always #2.5 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  int m_f = 0, m_t = 0, m_sec = 1, m_vec = 0;

  // rows listed sector 6 .. sector 1 (msb .. lsb)
  localparam logic [17:0] ROW_F1_INC = {3'b100, 3'b101, 3'b001, 3'b011, 3'b010, 3'b110};
  localparam logic [17:0] ROW_F1_DEC = {3'b001, 3'b011, 3'b010, 3'b110, 3'b100, 3'b101};
  localparam logic [17:0] ROW_F0_INC = {3'b110, 3'b100, 3'b101, 3'b001, 3'b011, 3'b010};
  localparam logic [17:0] ROW_F0_DEC = {3'b011, 3'b010, 3'b110, 3'b100, 3'b101, 3'b001};

  function automatic int exp_vec(int f, int t, int s);
    logic [17:0] row;
    if (t == 0) return (((s % 2) == 1) == (f == 1)) ? 7 : 0;
    if (f == 1) row = (t == 1) ? ROW_F1_INC : ROW_F1_DEC;
    else        row = (t == 1) ? ROW_F0_INC : ROW_F0_DEC;
    return int'(row[(s-1)*3 +: 3]);
  endfunction

  function automatic int exp_sector(int a);
    return (((12 * a + (1 << AW)) / (1 << (AW + 1))) % 6) + 1;
  endfunction

  function automatic int enc_t(int t);
    return (t == 1) ? 1 : (t == -1) ? 3 : 0;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all(string tag);
    chk(tag == "" ? "R3 flux state" : tag, int'(flux_state), m_f);
    chk(tag == "" ? "R4 torque state" : tag, int'(torq_state), enc_t(m_t));
    chk(tag == "" ? "R5 sector" : tag, int'(sector), m_sec);
    chk(tag == "" ? ((m_t == 0) ? "R7 zero pattern" : "R6 active pattern") : tag,
        int'(sw_vec), m_vec);
  endtask

  // called just after a falling edge
  task automatic step(int a, int fr, int fe, int tr, int te);
    int e, h;
    angle = AW'(a); flux_ref = DW'(fr); flux_est = DW'(fe);
    torq_ref = DW'(tr); torq_est = DW'(te); sample = 1'b1;
    e = fr - fe; h = int'(flux_band) / 2;
    if (e > h) m_f = 1; else if (e < -h) m_f = 0;
    e = tr - te; h = int'(torq_band) / 2;
    if (e > h) m_t = 1;
    else if (e < -h) m_t = -1;
    else if (m_t == 1 && e <= 0) m_t = 0;
    else if (m_t == -1 && e >= 0) m_t = 0;
    m_sec = exp_sector(a);
    m_vec = exp_vec(m_f, m_t, m_sec);
    @(posedge clk); @(negedge clk);
    sample = 1'b0;
    check_all("");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_all("R1 reset state");
    rst = 1'b0;

    // R3: flux hysteresis, band 20 then 40
    step(0, 50, 200, 0, 0);
    step(0, 110, 100, 0, 0);
    step(0, 111, 100, 0, 0);
    step(0, 90, 100, 0, 0);
    step(0, 89, 100, 0, 0);
    flux_band = 8'd40;
    step(0, 115, 100, 0, 0);
    step(0, 121, 100, 0, 0);
    step(0, 80, 100, 0, 0);
    step(0, 79, 100, 0, 0);
    flux_band = 8'd20;

    // R4: torque hysteresis; same-edge state flip and pattern choice
    step(43, 200, 50, 10, 0);
    step(43, 200, 50, 11, 0);
    step(43, 200, 50, 5, 0);
    step(43, 200, 50, 0, 0);
    step(43, 200, 50, -5, 0);
    step(43, 200, 50, -11, 0);
    step(43, 200, 50, -3, 0);
    step(43, 200, 50, 0, 0);
    step(43, 200, 50, 11, 0);
    step(43, 200, 50, -1, 0);
    step(43, 200, 50, 11, 0);
    step(43, 200, 50, -11, 0);
    torq_band = 8'd60;
    step(43, 200, 50, 25, -5);
    torq_band = 8'd20;

    // R2: no strobe, wild inputs, outputs hold
    @(posedge clk); @(negedge clk);
    angle = 8'd130; flux_ref = 8'd0; flux_est = 8'd255;
    torq_ref = 8'sd100; torq_est = -8'sd100;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_all("R2 hold without strobe");

    // R5/R6/R7: every angle code under every flux/torque combination
    for (int a = 0; a < (1 << AW); a++)
      for (int f = 0; f < 2; f++)
        for (int t = -1; t <= 1; t++)
          step(a, f ? 200 : 50, f ? 50 : 200,
               (t == 1) ? 100 : (t == -1) ? -100 : 0,
               (t == 1) ? -100 : (t == -1) ? 100 : 0);

    // R1: reset mid-run wins over a strobe
    step(100, 200, 50, 100, -100);
    rst = 1'b1; sample = 1'b1;
    @(posedge clk); @(negedge clk);
    sample = 1'b0;
    m_f = 0; m_t = 0; m_sec = 1; m_vec = 0;
    check_all("R1 reset mid-run");
    rst = 1'b0;
    step(0, 100, 100, 0, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule